// File: doc/BRIEF.md
# HDLC Frame Receiver with Tagged Receive Queue

This block takes a serial bit stream that carries HDLC frames, such as a T1 facility data link, and turns it into bytes that a host can read. It finds the 0x7E flags that bound each frame. It removes the zero that a sender inserts after five ones, and it spots the abort pattern of seven ones. The frame check sequence is verified with CRC-16/CCITT: polynomial x^16+x^12+x^5+1, preset to all ones, bits taken least significant first. A frame is good when the register, run over the data and the two check bytes, ends at 0xF0B8. The check bytes never reach the queue. Data bytes go into a 16-entry queue, and each entry carries three tags: first byte of a message, last byte of a message, and last byte of a good message.

A bit is taken on each clock where `rx_en` is high. The host reads through a one-bit address. Address 0 is the status word. Address 1 is the data byte at the head of the queue, and reading it pops that entry. Read data is combinational, and the side effect of a read (clearing or popping) takes place at the clock edge that ends the read cycle.

The framing state machine has two states. HUNT discards bits until a flag arrives. FRAME assembles bytes. The transitions are: HUNT to FRAME on a flag (open); FRAME to FRAME on a flag (close the current frame and open the next); FRAME to HUNT on seven ones (abort). The receiver holds the three most recent bytes back. A byte is written only once three newer bytes exist, or when the frame ends. This is how the two check bytes are dropped and how the last data byte receives its closing tag.

Top module: `hdlc_rx_tagged`

## Requirements
- R1: Bytes between two 0x7E flags are assembled least significant bit first. All but the last two bytes are written to the queue in arrival order, and the last two are taken as the check sequence. An address-1 read returns them in that order.
- R2: Inside a frame, a zero that follows five consecutive ones is removed and is not part of the data.
- R3: When a frame closes with a check failure or a bit count that is not a whole number of bytes, status bit 6 (CRC error) becomes set. That frame's closing byte then has no packet-OK tag.
- R4: The seventh consecutive one sets status bit 7 (abort) and returns the receiver to HUNT. If the aborted frame holds three bytes, the oldest held byte is written with the closing tag and no packet-OK tag, and the two newer bytes are dropped.
- R5: A byte that arrives while the queue holds 16 entries is dropped and sets status bit 5 (overrun). The frame it belongs to then never gets a packet-OK tag.
- R6: Every frame that a flag closes and that holds at least three bytes sets status bit 4 (message checked).
- R7: Status bits 7 to 4 stay set until an address-0 read clears them. An event in the same cycle as that read remains set afterwards.
- R8: Status bit 3 is high exactly while the queue is empty.
- R9: Status bits 2, 1 and 0 show the packet-OK, closing and opening tags of the head entry. Opening marks the first byte written for a frame, and all three tags read 0 while the queue is empty.
- R10: An address-1 read of an empty queue returns 0x00 and changes nothing.
- R11: After reset, status reads 0x08. A frame of fewer than three bytes is dropped without any write or event.
- R12: A clock with `rx_en` low takes no bit, whatever `rx_bit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Take `rx_bit` on this clock |
| rx_bit | input | 1 | Serial line bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 1 | 0 = status word, 1 = queue data (pops) |
| rd_data | output | 8 | Read data for the addressed word |

## Verification
The bench sends several frame patterns, and each one separates a different fault. A good frame whose data includes 0xFF and 0x7E requires zero removal to be correct and cannot be confused with a flag. A one-byte frame shows the opening and closing tags landing on the same entry. A frame with one flipped check bit separates the good-residue path from the bad one. A frame cut off by seven ones shows which held bytes survive an abort, and a 20-byte frame against the 16-entry queue shows overrun and the loss of the packet-OK tag. Runt frames, idle gaps with a toggling line, and a status read that falls in the same cycle as an abort cover the discard, enable and clear-versus-set rules.

// File: rtl/hdrx_pkg.sv
`timescale 1ns/1ps
package hdrx_pkg;

    localparam logic [15:0] CRC_INIT    = 16'hFFFF;
    localparam logic [15:0] CRC_RPOLY   = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [7:0]  FLAG_BYTE   = 8'h7E;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } rx_state_t;

    typedef struct packed {
        logic ok;
        logic close;
        logic open;
    } tag_t;

    // bitwise reflected CRC over one byte, LSB first
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_RPOLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdrx_fifo.sv
`timescale 1ns/1ps
module hdrx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    // DEPTH must be a power of two so the pointers wrap by overflow
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      count;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R10
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R8
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == 1) |=> empty);

endmodule

// File: rtl/hdrx_deframer.sv
`timescale 1ns/1ps
module hdrx_deframer
    import hdrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       fifo_full,
    output logic       wr_valid,
    output logic [7:0] wr_data,
    output tag_t       wr_tag,
    output logic       ev_abort,
    output logic       ev_crcerr,
    output logic       ev_ovr,
    output logic       ev_done
);
    rx_state_t   state, state_nx;
    logic [2:0]  ones;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  pend [3];
    logic [1:0]  pcnt;
    logic [15:0] crc;
    logic        wrote;
    logic        ovr_frm;

    logic       abort_hit, flag_hit, stuff_hit, long_one, data_bit, byte_done;
    logic       hold_full, close_hit, frame_good;
    logic [7:0] new_byte;

    always_comb begin
        abort_hit  = bit_en &  bit_in & (ones == 3'd6);
        flag_hit   = bit_en & ~bit_in & (ones == 3'd6);
        stuff_hit  = bit_en & ~bit_in & (ones == 3'd5);
        long_one   = bit_in & (ones >= 3'd5);
        data_bit   = bit_en & (state == ST_FRAME) & ~stuff_hit & ~flag_hit & ~long_one;
        byte_done  = data_bit & (bitcnt == 3'd7);
        new_byte   = {bit_in, shreg[7:1]};
        hold_full  = (pcnt == 2'd3);
        close_hit  = (state == ST_FRAME) & (flag_hit | abort_hit);
        frame_good = (crc == CRC_RESIDUE) & (bitcnt == 3'd6);

        wr_valid     = hold_full & (byte_done | close_hit);
        wr_data      = pend[0];
        wr_tag.open  = ~wrote;
        wr_tag.close = close_hit;
        wr_tag.ok    = close_hit & flag_hit & frame_good & ~ovr_frm;

        ev_done   = close_hit & flag_hit & hold_full;
        ev_crcerr = ev_done & ~frame_good;
        ev_abort  = abort_hit;
        ev_ovr    = wr_valid & fifo_full;

        state_nx = state;
        unique case (state)
            ST_HUNT:  if (flag_hit)  state_nx = ST_FRAME;
            ST_FRAME: if (abort_hit) state_nx = ST_HUNT;
            default:  state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones    <= 3'd0;
            bitcnt  <= 3'd0;
            shreg   <= 8'd0;
            pcnt    <= 2'd0;
            crc     <= CRC_INIT;
            wrote   <= 1'b0;
            ovr_frm <= 1'b0;
            for (int i = 0; i < 3; i++) pend[i] <= 8'd0;
        end else begin
            if (bit_en)
                ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
            if (flag_hit) begin
                bitcnt  <= 3'd0;
                pcnt    <= 2'd0;
                crc     <= CRC_INIT;
                wrote   <= 1'b0;
                ovr_frm <= 1'b0;
            end else begin
                if (data_bit) begin
                    shreg  <= new_byte;
                    bitcnt <= bitcnt + 3'd1;
                    if (byte_done) begin
                        crc <= crc16_byte(crc, new_byte);
                        if (hold_full) begin
                            pend[0] <= pend[1];
                            pend[1] <= pend[2];
                            pend[2] <= new_byte;
                        end else begin
                            if (pcnt == 2'd0)      pend[0] <= new_byte;
                            else if (pcnt == 2'd1) pend[1] <= new_byte;
                            else                   pend[2] <= new_byte;
                            pcnt <= pcnt + 2'd1;
                        end
                    end
                end
                if (wr_valid) begin
                    wrote <= 1'b1;
                    if (fifo_full) ovr_frm <= 1'b1;
                end
                if (abort_hit) pcnt <= 2'd0;
            end
        end
    end

    // R4
    abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_in && ones == 3'd6) |=> (state == ST_HUNT));

    // R1
    flag_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_in && ones == 3'd6) |=> (state == ST_FRAME && pcnt == 2'd0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ones) && $stable(bitcnt) && $stable(state)));

endmodule

// File: rtl/hdlc_rx_tagged.sv
`timescale 1ns/1ps
module hdlc_rx_tagged
    import hdrx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_bit,
    input  logic       rd_en,
    input  logic       rd_addr,
    output logic [7:0] rd_data
);
    localparam int ENTRY_W = 8 + $bits(tag_t);

    logic       wr_valid, ev_abort, ev_crcerr, ev_ovr, ev_done;
    logic [7:0] wr_data;
    tag_t       wr_tag, head_tag;
    logic       q_push, q_pop, q_empty, q_full;
    logic [ENTRY_W-1:0] q_rdata;
    logic [3:0] events, sticky;
    logic       status_rd;

    hdrx_deframer u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (rx_en),
        .bit_in    (rx_bit),
        .fifo_full (q_full),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_tag    (wr_tag),
        .ev_abort  (ev_abort),
        .ev_crcerr (ev_crcerr),
        .ev_ovr    (ev_ovr),
        .ev_done   (ev_done)
    );

    assign q_push = wr_valid & ~q_full;
    assign q_pop  = rd_en & rd_addr & ~q_empty;

    hdrx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata ({wr_tag, wr_data}),
        .pop   (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full)
    );

    assign head_tag  = q_empty ? tag_t'(3'b000) : tag_t'(q_rdata[ENTRY_W-1:8]);
    assign events    = {ev_abort, ev_crcerr, ev_ovr, ev_done};
    assign status_rd = rd_en & ~rd_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky <= 4'd0;
        else        sticky <= (status_rd ? 4'd0 : sticky) | events;
    end

    always_comb begin
        if (rd_addr) rd_data = q_empty ? 8'h00 : q_rdata[7:0];
        else         rd_data = {sticky, q_empty, head_tag.ok, head_tag.close, head_tag.open};
    end

    // R7
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && events == 4'd0) |=> (sticky == 4'd0));

    // R7
    event_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (events != 4'd0) |=> ((sticky & $past(events)) == $past(events)));

endmodule

// File: tb/hdlc_rx_tagged_tb.sv
`timescale 1ns/1ps
module hdlc_rx_tagged_tb;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_en = 1'b0, rx_bit = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    hdlc_rx_tagged u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct { logic [7:0] d; logic [2:0] t; } exp_t;  // t = {ok, close, open}
    exp_t q[$];

    int checks = 0, failures = 0;
    bit gap_mode = 0;
    int tx_ones = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic send_bit(input bit b);
        if (gap_mode) begin
            @(negedge clk); rx_en = 1'b0; rx_bit = ~b;
        end
        @(negedge clk); rx_en = 1'b1; rx_bit = b;
    endtask

    task automatic idle();
        @(negedge clk); rx_en = 1'b0;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit(i != 0 && i != 7);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i]);
            if (b[i]) tx_ones++; else tx_ones = 0;
            if (tx_ones == 5) begin send_bit(1'b0); tx_ones = 0; end
        end
    endtask

    // driver: sends a complete frame and pushes the entries the queue should hold
    task automatic send_frame(input logic [7:0] data [], input bit bad);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        bit ovr_seen = 0;
        int n = data.size();
        send_flag();
        foreach (data[i]) begin send_byte(data[i]); c = ref_crc(c, data[i]); end
        fcs = ~c;
        if (bad) fcs = fcs ^ 16'h0001;
        send_byte(fcs[7:0]);
        send_byte(fcs[15:8]);
        send_flag();
        idle();
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit cl = (i == n - 1);
            e.d = data[i];
            e.t = {cl && !bad && !ovr_seen, cl, i == 0};
            if (q.size() < 16) q.push_back(e); else ovr_seen = 1;
        end
    endtask

    task automatic read_reg(input bit a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // monitor: pops expected entries and compares them with what the queue yields
    task automatic drain();
        logic [7:0] st, dv;
        while (q.size() > 0) begin
            exp_t e = q.pop_front();
            read_reg(1'b0, st);
            chk(st[3:0] == {1'b0, e.t}, "R9 head tags", st[3:0], {1'b0, e.t});
            read_reg(1'b1, dv);
            chk(dv == e.d, "R1 data byte", dv, e.d);
        end
        read_reg(1'b0, st);
        chk(st == 8'h08, "R8 empty after drain", st, 8'h08);
    endtask

    initial begin
        logic [7:0] st, dv;
        logic [7:0] fr [];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R10 empty data read
        read_reg(1'b0, st); chk(st == 8'h08, "R11 reset status", st, 8'h08);
        read_reg(1'b1, dv); chk(dv == 8'h00, "R10 empty data read", dv, 8'h00);
        read_reg(1'b0, st); chk(st == 8'h08, "R10 no change after empty read", st, 8'h08);

        send_flag(); send_flag(); idle();

        // R2 stuffing with 0xFF and 0x7E data, R6 checked message
        fr = '{8'h7E, 8'hFF, 8'h05};
        send_frame(fr, 1'b0);
        fr = '{8'hA5};
        send_frame(fr, 1'b0);
        read_reg(1'b0, st); chk(st == 8'h11, "R6 R2 status after good frames", st, 8'h11);
        drain();

        // R3 bad check sequence
        fr = '{8'h01, 8'h02};
        send_frame(fr, 1'b1);
        read_reg(1'b0, st); chk(st == 8'h51, "R3 crc error status", st, 8'h51);
        drain();

        // R4 abort mid-frame
        send_flag();
        send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_flag(); idle();
        q.push_back('{8'h10, 3'b001});
        q.push_back('{8'h20, 3'b010});
        read_reg(1'b0, st); chk(st == 8'h81, "R4 abort status", st, 8'h81);
        drain();

        // R11 runt frame discarded
        send_flag(); send_byte(8'hAA); send_byte(8'h55); send_flag(); idle();
        read_reg(1'b0, st); chk(st == 8'h08, "R11 runt dropped", st, 8'h08);

        // R5 overrun with a 20-byte frame
        fr = new[20];
        foreach (fr[i]) fr[i] = 8'(i * 13 + 1);
        send_frame(fr, 1'b0);
        read_reg(1'b0, st); chk(st == 8'h31, "R5 overrun status", st, 8'h31);
        chk(q.size() == 16, "R5 model depth", q.size(), 16);
        drain();

        // R12 idle cycles with a toggling line between bits
        gap_mode = 1;
        fr = '{8'h3C, 8'hF8, 8'h1F, 8'h00};
        send_frame(fr, 1'b0);
        gap_mode = 0;
        read_reg(1'b0, st); chk(st == 8'h11, "R12 gapped frame status", st, 8'h11);
        drain();

        // R7 status read in the same cycle as an abort event
        fr = '{8'h42};
        send_frame(fr, 1'b0);
        send_flag();
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        @(negedge clk); rx_en = 1'b1; rx_bit = 1'b1; rd_en = 1'b1; rd_addr = 1'b0;
        #1 st = rd_data;
        chk(st[7:4] == 4'b0001, "R7 sticky before clear", st[7:4], 4'b0001);
        @(negedge clk); rx_en = 1'b0; rd_en = 1'b0;
        read_reg(1'b0, st);
        chk(st[7:4] == 4'b1000, "R7 same-cycle event kept", st[7:4], 4'b1000);
        send_bit(1'b1); send_flag(); idle();
        drain();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule